// File: doc/BRIEF.md
# CAN Receiver Status Flag Register

This block holds the 8-bit receiver flag register of a CAN controller. It combines four event flags with two 2-bit error-state fields. The event flags are wake-up, error-state change, overrun and receive-buffer-full. The two error-state fields are derived from the transmit and receive error counters. The host clears an event flag by writing 1 to its bit. The error-state fields cannot be written.

The flags feed four interrupt request outputs, and each request has its own enable bit. The error-state change flag blocks further updates. While that flag is pending, both error-state fields stay frozen. The fields catch up with the counters only after the host clears the flag, and that catch-up can raise the flag again.

An initialization mode holds the event flags cleared and blocks host writes. The error-state fields keep tracking the counters during initialization mode.

Top module: `can_rx_flag_reg`

## Requirements
- R1: After synchronous reset, `rd_data` reads 0x00 and all four interrupt outputs are low. The bit layout from bit 7 down to bit 0 is: wake-up flag, status-change flag, receive state [1:0] at bits 5:4, transmit state [1:0] at bits 3:2, overrun flag, receive-full flag.
- R2: When a host write is accepted, a 1 in bit 7, 6, 1 or 0 of `wr_data` clears the matching flag. A 0 in those bits leaves the flag unchanged.
- R3: Host writes to bits 5:2 have no effect on the state fields.
- R4: While `init_req` and `init_ack` are both high, the event flags read 0 and hardware sets are suppressed. Host writes are accepted only while both `init_req` and `init_ack` are low.
- R5: The state fields keep following the counters during initialization mode, and no status-change flag is raised then.
- R6: The wake-up flag sets in the cycle after `sleep_mode` and `bus_activity` are both high. Bus activity alone does not set it.
- R7: Each counter maps to a state as follows: below 96 gives 00, 96 to 127 gives 01, 128 and above gives 10. The transmit state reads 11 whenever `bus_off` is high.
- R8: When the status-change flag is clear and the classified state differs from the stored fields, both fields and the status-change flag update on the same clock edge.
- R9: While the status-change flag is set, the state fields hold. The edge that clears the flag leaves them unchanged. On the next edge they take the current state and raise the flag again if they differ.
- R10: When a hardware set and a host clear of the same flag arrive in the same cycle, the flag ends up set.
- R11: A one-cycle pulse on `ovr_pulse` or `rxf_pulse` sets the overrun flag or the receive-full flag on the next edge.
- R12: Each interrupt output equals its flag ANDed with its enable bit and changes on the same edge as the flag. The enable bits in `irq_en` are: bit 3 wake-up, bit 2 status change, bit 1 overrun, bit 0 receive-full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_req | input | 1 | Initialization mode request |
| init_ack | input | 1 | Initialization mode acknowledge |
| sleep_mode | input | 1 | Controller is in sleep mode |
| bus_activity | input | 1 | Activity seen on the CAN bus |
| tx_err_cnt | input | CNT_W | Transmit error counter |
| rx_err_cnt | input | CNT_W | Receive error counter |
| bus_off | input | 1 | Transmitter is bus-off |
| ovr_pulse | input | 1 | Receive overrun event pulse |
| rxf_pulse | input | 1 | Receive buffer filled pulse |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write data |
| irq_en | input | 4 | Interrupt enables {wake, status, overrun, rx-full} |
| rd_data | output | 8 | Register contents |
| irq_wake | output | 1 | Wake-up interrupt request |
| irq_stat | output | 1 | Status-change interrupt request |
| irq_ovr | output | 1 | Overrun interrupt request |
| irq_rxf | output | 1 | Receive-full interrupt request |

## Verification
The bench builds the block with its default parameters: 8-bit counters and thresholds at 96 and 128. With these values the directed cases can place each counter exactly on a threshold (95, 96, 127, 128) and at the full-scale value 255. Random counter values are drawn mostly from those boundary points. This lets the bench walk the freeze-and-resynchronize sequence of the status-change flag through every state transition, including bus-off. Random toggling of the two initialization handshake signals also reaches the half-entered states, where flags may set but host writes are still refused.

// File: rtl/can_flag_pkg.sv
package can_flag_pkg;

  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'b00,
    ST_WARN    = 2'b01,
    ST_PASSIVE = 2'b10,
    ST_BUSOFF  = 2'b11
  } err_state_t;

  // event flag slots in the internal vector and in irq_en
  localparam int EV_RXF  = 0;
  localparam int EV_OVR  = 1;
  localparam int EV_CSC  = 2;
  localparam int EV_WAKE = 3;
  localparam int EV_N    = 4;

  // register bit positions that the host sees
  localparam int BIT_WAKE = 7;
  localparam int BIT_CSC  = 6;
  localparam int BIT_OVR  = 1;
  localparam int BIT_RXF  = 0;

endpackage

// File: rtl/can_err_classify.sv
module can_err_classify #(
  parameter int CNT_W       = 8,
  parameter int WARN_LIM    = 96,
  parameter int PASSIVE_LIM = 128,
  parameter bit HAS_BUSOFF  = 1'b0
) (
  input  logic [CNT_W-1:0]        cnt,
  input  logic                    bus_off,
  output can_flag_pkg::err_state_t state
);
  import can_flag_pkg::*;

  localparam logic [CNT_W-1:0] WARN_T    = CNT_W'(WARN_LIM);
  localparam logic [CNT_W-1:0] PASSIVE_T = CNT_W'(PASSIVE_LIM);

  always_comb begin
    if (HAS_BUSOFF && bus_off)  state = ST_BUSOFF;
    else if (cnt >= PASSIVE_T)  state = ST_PASSIVE;
    else if (cnt >= WARN_T)     state = ST_WARN;
    else                        state = ST_ACTIVE;
  end

endmodule

// File: rtl/can_status_track.sv
module can_status_track (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     pending,
  input  can_flag_pkg::err_state_t cur_rx,
  input  can_flag_pkg::err_state_t cur_tx,
  output can_flag_pkg::err_state_t rx_state,
  output can_flag_pkg::err_state_t tx_state,
  output logic                     change
);
  import can_flag_pkg::*;

  // fields follow the live state only while no status-change flag is pending
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_state <= ST_ACTIVE;
      tx_state <= ST_ACTIVE;
    end else if (!pending) begin
      rx_state <= cur_rx;
      tx_state <= cur_tx;
    end
  end

  assign change = !pending && ((cur_rx != rx_state) || (cur_tx != tx_state));

endmodule

// File: rtl/can_w1c_flag.sv
module can_w1c_flag (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic set,
  input  logic clr,
  output logic flag,
  output logic flag_nxt
);

  // a hardware set wins over a host clear in the same cycle
  always_comb begin
    if (hold)      flag_nxt = 1'b0;
    else if (set)  flag_nxt = 1'b1;
    else if (clr)  flag_nxt = 1'b0;
    else           flag_nxt = flag;
  end

  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= flag_nxt;
  end

endmodule

// File: rtl/can_rx_flag_reg.sv
module can_rx_flag_reg #(
  parameter int CNT_W       = 8,
  parameter int WARN_LIM    = 96,
  parameter int PASSIVE_LIM = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init_req,
  input  logic             init_ack,
  input  logic             sleep_mode,
  input  logic             bus_activity,
  input  logic [CNT_W-1:0] tx_err_cnt,
  input  logic [CNT_W-1:0] rx_err_cnt,
  input  logic             bus_off,
  input  logic             ovr_pulse,
  input  logic             rxf_pulse,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic [3:0]       irq_en,
  output logic [7:0]       rd_data,
  output logic             irq_wake,
  output logic             irq_stat,
  output logic             irq_ovr,
  output logic             irq_rxf
);
  import can_flag_pkg::*;

  logic       init_mode;
  logic       host_wr;
  err_state_t cur_rx, cur_tx, rx_state, tx_state;
  logic       stat_change;
  logic [EV_N-1:0] evt_set, evt_clr, evt_q, evt_nxt, irq_q;

  assign init_mode = init_req & init_ack;
  assign host_wr   = wr_en & ~init_req & ~init_ack;

  can_err_classify #(
    .CNT_W(CNT_W), .WARN_LIM(WARN_LIM), .PASSIVE_LIM(PASSIVE_LIM), .HAS_BUSOFF(1'b0)
  ) u_cls_rx (
    .cnt(rx_err_cnt), .bus_off(1'b0), .state(cur_rx)
  );

  can_err_classify #(
    .CNT_W(CNT_W), .WARN_LIM(WARN_LIM), .PASSIVE_LIM(PASSIVE_LIM), .HAS_BUSOFF(1'b1)
  ) u_cls_tx (
    .cnt(tx_err_cnt), .bus_off(bus_off), .state(cur_tx)
  );

  can_status_track u_track (
    .clk(clk), .rst(rst), .pending(evt_q[EV_CSC]),
    .cur_rx(cur_rx), .cur_tx(cur_tx),
    .rx_state(rx_state), .tx_state(tx_state), .change(stat_change)
  );

  always_comb begin
    evt_set          = '0;
    evt_set[EV_WAKE] = sleep_mode & bus_activity;
    evt_set[EV_CSC]  = stat_change;
    evt_set[EV_OVR]  = ovr_pulse;
    evt_set[EV_RXF]  = rxf_pulse;
    evt_clr          = '0;
    if (host_wr) begin
      evt_clr[EV_WAKE] = wr_data[BIT_WAKE];
      evt_clr[EV_CSC]  = wr_data[BIT_CSC];
      evt_clr[EV_OVR]  = wr_data[BIT_OVR];
      evt_clr[EV_RXF]  = wr_data[BIT_RXF];
    end
  end

  for (genvar i = 0; i < EV_N; i++) begin : g_evt
    can_w1c_flag u_flag (
      .clk(clk), .rst(rst), .hold(init_mode),
      .set(evt_set[i]), .clr(evt_clr[i]),
      .flag(evt_q[i]), .flag_nxt(evt_nxt[i])
    );

    always_ff @(posedge clk) begin
      if (rst) irq_q[i] <= 1'b0;
      else     irq_q[i] <= evt_nxt[i] & irq_en[i];
    end
  end

  assign rd_data  = {evt_q[EV_WAKE], evt_q[EV_CSC], rx_state, tx_state,
                     evt_q[EV_OVR], evt_q[EV_RXF]};
  assign irq_wake = irq_q[EV_WAKE];
  assign irq_stat = irq_q[EV_CSC];
  assign irq_ovr  = irq_q[EV_OVR];
  assign irq_rxf  = irq_q[EV_RXF];

endmodule

// File: rtl/can_rx_flag_chk.sv
module can_rx_flag_chk (
  input logic       clk,
  input logic       rst,
  input logic       init_req,
  input logic       init_ack,
  input logic       bus_off,
  input logic       ovr_pulse,
  input logic [7:0] rd_data,
  input logic       irq_wake,
  input logic       irq_stat,
  input logic       irq_ovr,
  input logic       irq_rxf
);

  logic [3:0] irq_v, flag_v;
  assign irq_v  = {irq_wake, irq_stat, irq_ovr, irq_rxf};
  assign flag_v = {rd_data[7], rd_data[6], rd_data[1], rd_data[0]};

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (rd_data == 8'h00 && irq_v == 4'h0));

  p_init_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (init_req && init_ack) |=> (flag_v == 4'h0));

  p_busoff_state_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_off && !rd_data[6]) |=> (rd_data[3:2] == 2'b11));

  p_freeze_fields_r9: assert property (@(posedge clk) disable iff (rst)
    rd_data[6] |=> $stable(rd_data[5:2]));

  p_pulse_sets_r11: assert property (@(posedge clk) disable iff (rst)
    (ovr_pulse && !(init_req && init_ack)) |=> rd_data[1]);

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
    (!ovr_pulse && !rd_data[1]) |=> !rd_data[1]);

  p_irq_needs_flag_r12: assert property (@(posedge clk) disable iff (rst)
    (irq_v & ~flag_v) == 4'h0);

endmodule

bind can_rx_flag_reg can_rx_flag_chk u_chk (
  .clk(clk), .rst(rst), .init_req(init_req), .init_ack(init_ack),
  .bus_off(bus_off), .ovr_pulse(ovr_pulse), .rd_data(rd_data),
  .irq_wake(irq_wake), .irq_stat(irq_stat), .irq_ovr(irq_ovr), .irq_rxf(irq_rxf)
);

// File: tb/can_rx_flag_reg_test.sv
module can_rx_flag_reg_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       init_req = 0, init_ack = 0, sleep_mode = 0, bus_activity = 0;
  logic [7:0] tx_err_cnt = 0, rx_err_cnt = 0;
  logic       bus_off = 0, ovr_pulse = 0, rxf_pulse = 0, wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [3:0] irq_en = 4'hF;
  logic [7:0] rd_data;
  logic       irq_wake, irq_stat, irq_ovr, irq_rxf;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_reg = 8'h00;
  logic [3:0] exp_irq = 4'h0;

  always #4 clk = ~clk;

  can_rx_flag_reg uut (.*);

  function automatic logic [1:0] cls(input logic [7:0] c);
    if (c >= 8'd128)     return 2'b10;
    else if (c >= 8'd96) return 2'b01;
    else                 return 2'b00;
  endfunction

  // expected next {irq, reg} from the requirements
  function automatic logic [11:0] model_next(input logic [7:0] r);
    logic       init_m, wr_ok, csc, chg;
    logic [1:0] crx, ctx, nrx, ntx;
    logic [3:0] old, set, clr, nf;
    init_m = init_req & init_ack;
    wr_ok  = wr_en & ~init_req & ~init_ack;
    crx    = cls(rx_err_cnt);
    ctx    = bus_off ? 2'b11 : cls(tx_err_cnt);
    csc    = r[6];
    nrx    = csc ? r[5:4] : crx;
    ntx    = csc ? r[3:2] : ctx;
    chg    = !csc && ({crx, ctx} != r[5:2]);
    old    = {r[7], r[6], r[1], r[0]};
    set    = {sleep_mode & bus_activity, chg, ovr_pulse, rxf_pulse};
    clr    = wr_ok ? {wr_data[7], wr_data[6], wr_data[1], wr_data[0]} : 4'h0;
    nf     = init_m ? 4'h0 : (set | (old & ~clr));
    if (rst) return 12'h000;
    return {nf & irq_en, nf[3], nf[2], nrx, ntx, nf[1], nf[0]};
  endfunction

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // apply current inputs for one edge, then compare with the model
  task automatic tick(input string tag);
    logic [11:0] nx;
    nx = model_next(exp_reg);
    @(posedge clk); #1;
    exp_irq = nx[11:8];
    exp_reg = nx[7:0];
    check(tag, {irq_wake, irq_stat, irq_ovr, irq_rxf, rd_data}, {exp_irq, exp_reg});
  endtask

  task automatic step_lit(input string tag, input logic [7:0] lit);
    tick(tag);
    check(tag, {4'h0, rd_data}, {4'h0, lit});
    wr_en = 0; ovr_pulse = 0; rxf_pulse = 0;
  endtask

  task automatic host_write(input string tag, input logic [7:0] d, input logic [7:0] lit);
    wr_en = 1; wr_data = d;
    step_lit(tag, lit);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    tick("R1 reset");
    rst = 0;
    step_lit("R1 reset value", 8'h00);
    check("R1 irq after reset", {8'h00, irq_wake, irq_stat, irq_ovr, irq_rxf}, 12'h000);

    rxf_pulse = 1;           step_lit("R11 rxf pulse", 8'h01);
    check("R12 rxf irq", {11'h0, irq_rxf}, 12'h001);
    host_write("R2 write zero keeps", 8'h00, 8'h01);
    host_write("R2 write one clears", 8'h01, 8'h00);
    ovr_pulse = 1; wr_en = 1; wr_data = 8'h02;
    step_lit("R10 set beats clear", 8'h02);
    irq_en = 4'h0;           step_lit("R12 enable low", 8'h02);
    check("R12 masked irq", {11'h0, irq_ovr}, 12'h000);
    irq_en = 4'hF;
    host_write("R2 clear overrun", 8'h02, 8'h00);

    sleep_mode = 1;          step_lit("R6 sleep without activity", 8'h00);
    bus_activity = 1;        step_lit("R6 wake sets", 8'h80);
    sleep_mode = 0; bus_activity = 0;
    host_write("R2 clear wake", 8'h80, 8'h00);
    bus_activity = 1;        step_lit("R6 activity awake", 8'h00);
    bus_activity = 0;

    rx_err_cnt = 8'd95;      step_lit("R7 rx 95", 8'h00);
    rx_err_cnt = 8'd96;      step_lit("R8 rx warn", 8'h50);
    check("R12 status irq", {11'h0, irq_stat}, 12'h001);
    rx_err_cnt = 8'd130;     step_lit("R9 frozen", 8'h50);
    step_lit("R9 still frozen", 8'h50);
    host_write("R9 clear keeps fields", 8'h40, 8'h10);
    step_lit("R9 resync raises", 8'h60);
    host_write("R3 state write ignored", 8'h3C, 8'h60);
    rx_err_cnt = 8'd0;
    host_write("R9 clear again", 8'h40, 8'h20);
    step_lit("R8 back to active", 8'h40);
    host_write("R2 clear status", 8'h40, 8'h00);

    bus_off = 1;             step_lit("R7 bus off", 8'h4C);
    bus_off = 0; tx_err_cnt = 8'd100;
    host_write("R9 clear after bus off", 8'h40, 8'h0C);
    step_lit("R7 tx warn", 8'h44);
    tx_err_cnt = 8'd0;
    host_write("R9 clear tx", 8'h40, 8'h04);
    step_lit("R8 tx active", 8'h40);
    host_write("R2 clear", 8'h40, 8'h00);

    rxf_pulse = 1;           step_lit("R11 rxf before init", 8'h01);
    init_req = 1; init_ack = 1; step_lit("R4 init holds", 8'h00);
    rxf_pulse = 1;           step_lit("R4 set suppressed", 8'h00);
    rx_err_cnt = 8'd120;     step_lit("R5 tracks in init", 8'h10);
    init_ack = 0; rxf_pulse = 1; step_lit("R4 set after ack drop", 8'h11);
    host_write("R4 write refused", 8'h01, 8'h11);
    init_req = 0;
    host_write("R4 write accepted", 8'h01, 8'h10);
    rx_err_cnt = 8'd0;       step_lit("R8 leave warn", 8'h40);
    host_write("R2 clear", 8'h40, 8'h00);

    // random phase against the model
    void'($urandom(32'h5EED_0042));
    for (int n = 0; n < 4000; n++) begin
      rst          = ($urandom_range(0, 499) == 0);
      if ($urandom_range(0, 39) == 0) init_req = ~init_req;
      if ($urandom_range(0, 2) == 0)  init_ack = init_req;
      sleep_mode   = ($urandom_range(0, 3) == 0);
      bus_activity = ($urandom_range(0, 3) == 0);
      ovr_pulse    = ($urandom_range(0, 9) == 0);
      rxf_pulse    = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 29) == 0) bus_off = ~bus_off;
      if ($urandom_range(0, 14) == 0) begin
        case ($urandom_range(0, 6))
          0: rx_err_cnt = 8'd0;   1: rx_err_cnt = 8'd95;  2: rx_err_cnt = 8'd96;
          3: rx_err_cnt = 8'd127; 4: rx_err_cnt = 8'd128; 5: rx_err_cnt = 8'd255;
          default: rx_err_cnt = 8'($urandom);
        endcase
      end
      if ($urandom_range(0, 14) == 0) begin
        case ($urandom_range(0, 4))
          0: tx_err_cnt = 8'd0;   1: tx_err_cnt = 8'd96;  2: tx_err_cnt = 8'd127;
          3: tx_err_cnt = 8'd128; default: tx_err_cnt = 8'($urandom);
        endcase
      end
      wr_en   = ($urandom_range(0, 3) == 0);
      wr_data = 8'($urandom);
      if ($urandom_range(0, 49) == 0) irq_en = 4'($urandom);
      tick("R2 R8 R9 R10 R12 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule